// File: doc/BRIEF.md
# Programmable Tap Divider Timer

This block is a synchronous timer built on a binary up-counter. A two-bit selector picks one of four fixed counter stages as the output source, so the output can be taken from stage 8, 10, 13 or 16 of a sixteen-stage counter. Stage N is counter bit N-1. That bit toggles every 2^(N-1) counts and has a full period of 2^N clocks.

A mode input chooses between two uses of the block. In divider mode the output follows the chosen stage and forms a continuous square wave at the clock rate divided by 2^N. In single-transition mode the output starts low after a reset and rises once 2^(N-1) counts have elapsed. It then stays high until the next master reset, or until the block is switched to divider mode. A polarity input inverts the output in both modes.

Counting is gated whenever a reset is active. After power-on reset the block can start counting by itself through an internal one-cycle auto reset. If that path is disabled, the block stays idle until a master reset pulse has been applied and released.

Top module: `tap_timer`

## Requirements
- R1: While running, the counter advances by exactly one on each rising clock edge and wraps modulo 2^CNT_W.
- R2: tap_sel selects the output stage: 2'b00 selects stage STG_SEL0 (default 13), 2'b01 selects STG_SEL1 (10), 2'b10 selects STG_SEL2 (8), and 2'b11 selects STG_SEL3 (16). Stage N is counter bit N-1.
- R3: With div_mode=1 and inv_out=0, tmr_out equals the selected stage bit. After k counting edges following a reset release, it equals bit N-1 of k.
- R4: With div_mode=0 and inv_out=0, tmr_out is low after a master reset and goes high once 2^(N-1) counts have elapsed since the reset was released.
- R5: In single-transition mode the high output is held even after the selected stage bit falls again, including when the counter wraps.
- R6: A clock edge with div_mode=1 clears the single-transition latch, so the next return to div_mode=0 starts low until the stage bit rises again.
- R7: inv_out=1 inverts tmr_out in both modes and during reset.
- R8: While mreset is high the counter is cleared and held at zero. Counting resumes on the first edge after mreset falls.
- R9: With auto_rst_dis=0, the counter starts by itself after rst_n is released. The first edge is an internal clear, and the counter counts from the second edge on.
- R10: With auto_rst_dis=1, the counter stays at zero after rst_n is released until a master reset pulse has been applied and released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| auto_rst_dis | input | 1 | 1 disables the internal power-on start pulse |
| mreset | input | 1 | Master reset, active high; clears and halts the counter |
| tap_sel | input | 2 | Output stage selector |
| div_mode | input | 1 | 1 = square-wave divider, 0 = single transition |
| inv_out | input | 1 | 1 = inverted output polarity |
| tmr_out | output | 1 | Timer output |

## Verification
The bench builds the block with an 8-bit counter and stages 6, 4, 3 and 8 on the four selector codes. This keeps the full period of the longest stage at 256 clocks. With that setting the bench can observe the wrap of the counter in single-transition mode, both edges of every tap, and a full divider period for each selector code, all within a short run. The default 16-bit, stage 8/10/13/16 setting differs only in its parameters and uses the same logic.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

    // State of the reset and arming sequencer
    typedef struct packed {
        logic pend;   // first cycle after power-on reset, auto start pending
        logic armed;  // a reset has been seen; counting allowed once it ends
    } seq_state_t;

    // Stage numbers start at 1; counter bits start at 0
    function automatic int unsigned stage_to_bit(input int unsigned stage);
        return stage - 1;
    endfunction

endpackage

// File: rtl/tap_timer_seq.sv
module tap_timer_seq
    import tap_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_rst_dis,
    input  logic mreset,
    output logic clr_o,
    output logic run_o
);

    seq_state_t s_d, s_q;
    logic       clr;

    always_comb begin
        clr      = mreset | (s_q.pend & ~auto_rst_dis);
        s_d      = s_q;
        s_d.pend = 1'b0;
        if (clr) begin
            s_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pend  <= 1'b1;
            s_q.armed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clr_o = clr;
    assign run_o = s_q.armed & ~clr;

endmodule

// File: rtl/tap_timer_cnt.sv
module tap_timer_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr_i) begin
            c_d.cnt = '0;
        end else if (run_i) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.cnt <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o = c_q.cnt;

endmodule

// File: rtl/tap_timer_out.sv
module tap_timer_out
    import tap_timer_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned STG_SEL0 = 13,
    parameter int unsigned STG_SEL1 = 10,
    parameter int unsigned STG_SEL2 = 8,
    parameter int unsigned STG_SEL3 = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             clr_i,
    input  logic [1:0]       tap_sel,
    input  logic             div_mode,
    input  logic             inv_out,
    output logic             flag_o,
    output logic             out_o
);

    localparam int unsigned NUM_TAPS = 4;
    localparam int unsigned TAP_BIT [NUM_TAPS] = '{
        stage_to_bit(STG_SEL0), stage_to_bit(STG_SEL1),
        stage_to_bit(STG_SEL2), stage_to_bit(STG_SEL3)
    };

    typedef struct packed {
        logic flag;
    } out_state_t;

    logic [NUM_TAPS-1:0] tap_vec;
    logic                tap_bit;
    out_state_t          o_d, o_q;

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign tap_vec[t] = cnt_i[TAP_BIT[t]];
    end

    always_comb begin
        tap_bit = tap_vec[tap_sel];
        o_d     = o_q;
        if (div_mode || clr_i) begin
            o_d.flag = 1'b0;
        end else if (tap_bit) begin
            o_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q.flag <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign flag_o = o_q.flag;
    assign out_o  = inv_out ^ (div_mode ? tap_bit : (o_q.flag | tap_bit));

endmodule

// File: rtl/tap_timer.sv
module tap_timer #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned STG_SEL0 = 13,
    parameter int unsigned STG_SEL1 = 10,
    parameter int unsigned STG_SEL2 = 8,
    parameter int unsigned STG_SEL3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_rst_dis,
    input  logic       mreset,
    input  logic [1:0] tap_sel,
    input  logic       div_mode,
    input  logic       inv_out,
    output logic       tmr_out
);

    logic             clr;
    logic             run;
    logic             flag;
    logic [CNT_W-1:0] cnt;

    tap_timer_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_rst_dis (auto_rst_dis),
        .mreset       (mreset),
        .clr_o        (clr),
        .run_o        (run)
    );

    tap_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .run_i (run),
        .cnt_o (cnt)
    );

    tap_timer_out #(
        .CNT_W    (CNT_W),
        .STG_SEL0 (STG_SEL0),
        .STG_SEL1 (STG_SEL1),
        .STG_SEL2 (STG_SEL2),
        .STG_SEL3 (STG_SEL3)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt),
        .clr_i    (clr),
        .tap_sel  (tap_sel),
        .div_mode (div_mode),
        .inv_out  (inv_out),
        .flag_o   (flag),
        .out_o    (tmr_out)
    );

endmodule

// File: rtl/tap_timer_chk.sv
module tap_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mreset,
    input logic             div_mode,
    input logic             clr,
    input logic             run,
    input logic             flag,
    input logic [CNT_W-1:0] cnt
);

    // R1: one step per edge while running
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R8: master reset leaves the counter at zero
    assert_mreset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> cnt == '0);

    // R10: no movement while neither cleared nor running
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt));

    // R5: latched level survives in single-transition mode
    assert_latch_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !div_mode && !mreset) |=> flag);

    // R6: divider mode drops the latch
    assert_mode_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        div_mode |=> !flag);

endmodule

bind tap_timer tap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mreset   (mreset),
    .div_mode (div_mode),
    .clr      (clr),
    .run      (run),
    .flag     (flag),
    .cnt      (cnt)
);

// File: tb/tap_timer_test.sv
module tap_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_rst_dis = 1'b0;
    logic       mreset = 1'b0;
    logic [1:0] tap_sel = 2'b10;
    logic       div_mode = 1'b1;
    logic       inv_out = 1'b0;
    logic       tmr_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tap_timer #(
        .CNT_W(8), .STG_SEL0(6), .STG_SEL1(4), .STG_SEL2(3), .STG_SEL3(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .auto_rst_dis(auto_rst_dis), .mreset(mreset),
        .tap_sel(tap_sel), .div_mode(div_mode), .inv_out(inv_out), .tmr_out(tmr_out)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic        mode;
        logic        inv;
        logic [15:0] n;
        logic        exp;
    } vec_t;

    // stage per code (bench build): 00->6, 01->4, 10->3, 11->8
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 1'b1, 1'b0, 16'd3,   1'b0},  // R3 stage 3
        '{2'b10, 1'b1, 1'b0, 16'd4,   1'b1},
        '{2'b10, 1'b1, 1'b0, 16'd8,   1'b0},
        '{2'b10, 1'b1, 1'b1, 16'd4,   1'b0},  // R7
        '{2'b01, 1'b1, 1'b0, 16'd7,   1'b0},  // R2 stage 4
        '{2'b01, 1'b1, 1'b0, 16'd8,   1'b1},
        '{2'b01, 1'b1, 1'b0, 16'd16,  1'b0},
        '{2'b00, 1'b1, 1'b0, 16'd31,  1'b0},  // R2 stage 6
        '{2'b00, 1'b1, 1'b0, 16'd32,  1'b1},
        '{2'b11, 1'b1, 1'b0, 16'd127, 1'b0},  // R2 stage 8
        '{2'b11, 1'b1, 1'b0, 16'd128, 1'b1},
        '{2'b10, 1'b0, 1'b0, 16'd3,   1'b0},  // R4
        '{2'b10, 1'b0, 1'b0, 16'd4,   1'b1},
        '{2'b10, 1'b0, 1'b0, 16'd8,   1'b1},  // R5
        '{2'b10, 1'b0, 1'b0, 16'd300, 1'b1},  // R5 after wrap
        '{2'b10, 1'b0, 1'b1, 16'd4,   1'b0},  // R7
        '{2'b10, 1'b0, 1'b1, 16'd3,   1'b1},
        '{2'b11, 1'b0, 1'b0, 16'd127, 1'b0},
        '{2'b11, 1'b0, 1'b0, 16'd128, 1'b1},
        '{2'b11, 1'b0, 1'b0, 16'd256, 1'b1}   // R5 counter back at zero
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: tmr_out=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_mreset();
        mreset = 1'b1;
        @(negedge clk);
        mreset = 1'b0;
    endtask

    initial begin
        // reset state
        edges(2);
        #1 check("R7 reset out", tmr_out, 1'b0);
        inv_out = 1'b1;
        #1 check("R7 reset inverted", tmr_out, 1'b1);
        inv_out = 1'b0;

        // R9 auto start
        @(negedge clk);
        rst_n = 1'b1;
        edges(4);
        check("R9 auto start, 3 counts", tmr_out, 1'b0);
        edges(1);
        check("R9 auto start, 4 counts", tmr_out, 1'b1);

        // R10 auto disabled
        rst_n = 1'b0;
        auto_rst_dis = 1'b1;
        edges(2);
        rst_n = 1'b1;
        edges(20);
        check("R10 idle divider", tmr_out, 1'b0);
        div_mode = 1'b0;
        #1 check("R10 idle single", tmr_out, 1'b0);
        pulse_mreset();
        edges(4);
        check("R10 counts after pulse", tmr_out, 1'b1);

        // R8 held master reset
        mreset = 1'b1;
        edges(20);
        check("R8 held in reset", tmr_out, 1'b0);
        inv_out = 1'b1;
        #1 check("R8 R7 held in reset inverted", tmr_out, 1'b1);
        inv_out = 1'b0;
        mreset = 1'b0;
        edges(4);
        check("R4 R8 after release", tmr_out, 1'b1);

        // R6 mode change drops latch
        tap_sel = 2'b10;
        pulse_mreset();
        edges(8);
        check("R5 latched at 8", tmr_out, 1'b1);
        div_mode = 1'b1;
        #1 check("R3 divider view at 8", tmr_out, 1'b0);
        @(negedge clk);
        div_mode = 1'b0;
        #1 check("R6 latch cleared", tmr_out, 1'b0);
        edges(3);
        check("R6 R4 rises again at 12", tmr_out, 1'b1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            tap_sel  = VECS[i].sel;
            div_mode = VECS[i].mode;
            inv_out  = VECS[i].inv;
            pulse_mreset();
            edges(int'(VECS[i].n));
            check($sformatf("R1 R2 R3 R4 vector %0d", i), tmr_out, VECS[i].exp);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: tmr_out=%b expected=finished", tmr_out);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule